// File: doc/BRIEF.md
# Multi-Cycle Integer Divider with Overflow-Safe Flags

This block performs one integer division per request in one of four modes: 32-by-16 and 64-by-32, each either unsigned or signed. A request is a single-cycle `start` pulse that carries the mode, the divisor and the dividend. In the long modes the dividend is the pair `{src_hi, src_lo}`. In the short modes it is `src_lo` on its own. The core works on magnitudes with a restoring shift-subtract loop that produces one quotient bit per cycle. It then applies the signs and checks whether the quotient fits the destination width.

When the block finishes, it pulses `done` for one cycle. In that same cycle it gives per-destination write strobes, the result words and a flag-update strobe. The flags N, Z, V and C are held in the block as registers, so a flag that an operation leaves alone keeps its earlier value at the outputs. A zero divisor raises `div_zero` and changes nothing else. An overflowing quotient changes only some of the flags.

Top module: `div_unit`

## Requirements
- R1: A divisor that is zero at the mode's width (bits 15:0 in the short modes, all 32 bits in the long modes) pulses `div_zero` together with `done`. It asserts neither write strobe nor `flag_upd`, and it leaves the result and flag outputs unchanged.
- R2: Mode encoding is 0 = unsigned 32-by-16, 1 = signed 32-by-16, 2 = unsigned 64-by-32, 3 = signed 64-by-32. A successful short division pulses `we_lo` only, and `res_lo` becomes {remainder[15:0], quotient[15:0]}.
- R3: Mode 0 overflows when the quotient is greater than 0xFFFF. Mode 1 overflows when the quotient lies outside -32768..32767, so -32768 itself is a valid result.
- R4: On overflow, `flag_upd` pulses, V is set, Z and C are cleared, N keeps its previous value, neither write strobe fires, and `res_lo` and `res_hi` hold.
- R5: Every flag update clears C. On success V is cleared, N is the sign bit of the quotient at the result width (16 or 32 bits), and Z is set exactly when the quotient is zero at that width.
- R6: In modes 2 and 3 the dividend is {src_hi, src_lo}. On success both strobes pulse, `res_lo` takes the 32-bit quotient and `res_hi` the remainder. The operation overflows when the quotient does not fit 32 bits (unsigned for mode 2, signed for mode 3).
- R7: Signed division truncates toward zero, and the remainder carries the sign of the dividend.
- R8: `busy` rises on the edge that accepts `start`. `done` is a one-cycle pulse exactly 65 clock edges after that edge (2*DW+1), and `busy` falls on the same edge.
- R9: A `start` that arrives while `busy` is high is ignored, and the running operation completes with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| mode | input | 2 | Division mode (see R2) |
| src_hi | input | 32 | Upper dividend word (long modes) |
| src_lo | input | 32 | Lower dividend word, or the whole dividend in short modes |
| divisor | input | 32 | Divisor; short modes use bits 15:0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_lo | output | 32 | Packed short result, or long quotient |
| res_hi | output | 32 | Long remainder |
| we_lo | output | 1 | Write strobe for the low destination |
| we_hi | output | 1 | Write strobe for the high destination |
| flag_upd | output | 1 | Flags were updated by this operation |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| div_zero | output | 1 | Divide-by-zero exception pulse |

## Verification
The hardest behaviour to see from the ports is the N flag surviving an overflow. It is visible only when the previous successful operation left N set. The vector table therefore places every overflow case directly after a success whose quotient is negative at its width.

The signed boundary quotients (exactly -32768 and -2^31) and the short-mode divisor with zero low half but non-zero upper bits are reached with dedicated vectors. A second `start` with different operands is injected in the middle of a run to show that the request is dropped.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    DM_USHORT = 2'd0,
    DM_SSHORT = 2'd1,
    DM_ULONG  = 2'd2,
    DM_SLONG  = 2'd3
  } div_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  function automatic logic mode_signed(div_mode_e m);
    return (m == DM_SSHORT) || (m == DM_SLONG);
  endfunction

  function automatic logic mode_long(div_mode_e m);
    return (m == DM_ULONG) || (m == DM_SLONG);
  endfunction
endpackage

// File: rtl/div_prep.sv
module div_prep
  import div_pkg::*;
#(
  parameter int DW = 32
) (
  input  div_mode_e         mode,
  input  logic [DW-1:0]     hi_word,
  input  logic [DW-1:0]     lo_word,
  input  logic [DW-1:0]     dvs_word,
  output logic [2*DW-1:0]   mag_dvd,
  output logic [DW-1:0]     mag_dvs,
  output logic              quot_neg,
  output logic              rem_neg,
  output logic              dvs_zero
);
  localparam int HW  = DW / 2;
  localparam int DDW = 2 * DW;

  function automatic logic [DDW-1:0] abs_wide(logic [DDW-1:0] v, logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [DW-1:0] abs_narrow(logic [DW-1:0] v, logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  logic [DDW-1:0] dvd_ext;
  logic [DW-1:0]  dvs_ext;
  logic           dvd_sign;
  logic           dvs_sign;

  always_comb begin
    case (mode)
      DM_USHORT: begin
        dvd_ext = {{DW{1'b0}}, lo_word};
        dvs_ext = {{HW{1'b0}}, dvs_word[HW-1:0]};
      end
      DM_SSHORT: begin
        dvd_ext = {{DW{lo_word[DW-1]}}, lo_word};
        dvs_ext = {{HW{dvs_word[HW-1]}}, dvs_word[HW-1:0]};
      end
      default: begin
        dvd_ext = {hi_word, lo_word};
        dvs_ext = dvs_word;
      end
    endcase
    dvd_sign = mode_signed(mode) & dvd_ext[DDW-1];
    dvs_sign = mode_signed(mode) & dvs_ext[DW-1];
    mag_dvd  = abs_wide(dvd_ext, dvd_sign);
    mag_dvs  = abs_narrow(dvs_ext, dvs_sign);
    quot_neg = dvd_sign ^ dvs_sign;
    rem_neg  = dvd_sign;
    dvs_zero = (dvs_ext == '0);
  end
endmodule

// File: rtl/div_iter.sv
module div_iter #(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [2*DW-1:0]   dvd_in,
  input  logic [DW-1:0]     dvs_in,
  output logic [2*DW-1:0]   quot_mag,
  output logic [DW-1:0]     rem_mag
);
  localparam int DDW = 2 * DW;

  logic [DDW-1:0] q_r;
  logic [DW-1:0]  r_r;
  logic [DW-1:0]  d_r;
  logic [DW:0]    shifted;
  logic [DW:0]    trial;
  logic           fits;

  always_comb begin
    shifted = {r_r, q_r[DDW-1]};
    trial   = shifted - {1'b0, d_r};
    fits    = ~trial[DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r <= '0;
      r_r <= '0;
      d_r <= '0;
    end else if (load) begin
      q_r <= dvd_in;
      r_r <= '0;
      d_r <= dvs_in;
    end else if (step) begin
      r_r <= fits ? trial[DW-1:0] : shifted[DW-1:0];
      q_r <= {q_r[DDW-2:0], fits};
    end
  end

  assign quot_mag = q_r;
  assign rem_mag  = r_r;
endmodule

// File: rtl/div_post.sv
module div_post
  import div_pkg::*;
#(
  parameter int DW = 32
) (
  input  div_mode_e         mode,
  input  logic [2*DW-1:0]   quot_mag,
  input  logic [DW-1:0]     rem_mag,
  input  logic              quot_neg,
  input  logic              rem_neg,
  output logic [DW-1:0]     out_lo,
  output logic [DW-1:0]     out_hi,
  output logic              ovf,
  output logic              n_bit,
  output logic              z_bit
);
  localparam int HW  = DW / 2;
  localparam int DDW = 2 * DW;

  function automatic logic [DDW-1:0] apply_sign_q(logic [DDW-1:0] v, logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [DW-1:0] apply_sign_r(logic [DW-1:0] v, logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  logic [DDW-1:0] q_s;
  logic [DW-1:0]  r_s;

  always_comb begin
    q_s = apply_sign_q(quot_mag, quot_neg);
    r_s = apply_sign_r(rem_mag, rem_neg);
    case (mode)
      DM_USHORT: ovf = |quot_mag[DDW-1:HW];
      DM_SSHORT: ovf = (|quot_mag[DDW-1:HW]) ||
                       (quot_mag[HW-1] && !(quot_neg && quot_mag[HW-2:0] == '0));
      DM_ULONG:  ovf = |quot_mag[DDW-1:DW];
      default:   ovf = (|quot_mag[DDW-1:DW]) ||
                       (quot_mag[DW-1] && !(quot_neg && quot_mag[DW-2:0] == '0));
    endcase
    if (mode_long(mode)) begin
      out_lo = q_s[DW-1:0];
      out_hi = r_s;
      n_bit  = q_s[DW-1];
      z_bit  = (q_s[DW-1:0] == '0);
    end else begin
      out_lo = {r_s[HW-1:0], q_s[HW-1:0]};
      out_hi = '0;
      n_bit  = q_s[HW-1];
      z_bit  = (q_s[HW-1:0] == '0);
    end
  end
endmodule

// File: rtl/div_unit.sv
module div_unit
  import div_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] src_hi,
  input  logic [DW-1:0] src_lo,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] res_lo,
  output logic [DW-1:0] res_hi,
  output logic          we_lo,
  output logic          we_hi,
  output logic          flag_upd,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v,
  output logic          flag_c,
  output logic          div_zero
);
  localparam int DDW = 2 * DW;
  localparam int CW  = $clog2(DDW);

  div_state_e     st;
  logic [CW-1:0]  cnt;
  div_mode_e      mode_r;
  logic           qneg_r;
  logic           rneg_r;
  logic           dz_r;

  logic [DDW-1:0] p_mag_dvd;
  logic [DW-1:0]  p_mag_dvs;
  logic           p_qneg;
  logic           p_rneg;
  logic           p_dz;
  logic [DDW-1:0] quot_mag;
  logic [DW-1:0]  rem_mag;
  logic [DW-1:0]  post_lo;
  logic [DW-1:0]  post_hi;
  logic           post_ovf;
  logic           post_n;
  logic           post_z;

  // named events used by the bound checker
  logic           accept_evt;
  logic           step_evt;
  logic           fin_evt;
  logic           dz_evt;
  logic           ovf_evt;
  logic           ok_evt;

  assign accept_evt = start && (st == ST_IDLE);
  assign step_evt   = (st == ST_RUN);
  assign fin_evt    = (st == ST_FIN);
  assign dz_evt     = fin_evt && dz_r;
  assign ovf_evt    = fin_evt && !dz_r && post_ovf;
  assign ok_evt     = fin_evt && !dz_r && !post_ovf;
  assign busy       = (st != ST_IDLE);

  div_prep #(.DW(DW)) u_prep (
    .mode     (div_mode_e'(mode)),
    .hi_word  (src_hi),
    .lo_word  (src_lo),
    .dvs_word (divisor),
    .mag_dvd  (p_mag_dvd),
    .mag_dvs  (p_mag_dvs),
    .quot_neg (p_qneg),
    .rem_neg  (p_rneg),
    .dvs_zero (p_dz)
  );

  div_iter #(.DW(DW)) u_iter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_evt),
    .step     (step_evt),
    .dvd_in   (p_mag_dvd),
    .dvs_in   (p_mag_dvs),
    .quot_mag (quot_mag),
    .rem_mag  (rem_mag)
  );

  div_post #(.DW(DW)) u_post (
    .mode     (mode_r),
    .quot_mag (quot_mag),
    .rem_mag  (rem_mag),
    .quot_neg (qneg_r),
    .rem_neg  (rneg_r),
    .out_lo   (post_lo),
    .out_hi   (post_hi),
    .ovf      (post_ovf),
    .n_bit    (post_n),
    .z_bit    (post_z)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      mode_r <= DM_USHORT;
      qneg_r <= 1'b0;
      rneg_r <= 1'b0;
      dz_r   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept_evt) begin
          st     <= ST_RUN;
          cnt    <= '0;
          mode_r <= div_mode_e'(mode);
          qneg_r <= p_qneg;
          rneg_r <= p_rneg;
          dz_r   <= p_dz;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DDW - 1)) st <= ST_FIN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      we_lo    <= 1'b0;
      we_hi    <= 1'b0;
      flag_upd <= 1'b0;
      div_zero <= 1'b0;
      res_lo   <= '0;
      res_hi   <= '0;
      flag_n   <= 1'b0;
      flag_z   <= 1'b0;
      flag_v   <= 1'b0;
      flag_c   <= 1'b0;
    end else begin
      done     <= fin_evt;
      we_lo    <= ok_evt;
      we_hi    <= ok_evt && mode_long(mode_r);
      flag_upd <= ok_evt || ovf_evt;
      div_zero <= dz_evt;
      if (ok_evt) begin
        res_lo <= post_lo;
        if (mode_long(mode_r)) res_hi <= post_hi;
        flag_n <= post_n;
        flag_z <= post_z;
        flag_v <= 1'b0;
        flag_c <= 1'b0;
      end else if (ovf_evt) begin
        flag_z <= 1'b0;
        flag_v <= 1'b1;
        flag_c <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/div_unit_chk.sv
module div_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept_evt,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] res_lo,
  input logic [DW-1:0] res_hi,
  input logic          we_lo,
  input logic          we_hi,
  input logic          flag_upd,
  input logic          flag_n,
  input logic          flag_z,
  input logic          flag_v,
  input logic          div_zero
);
  localparam int DDW = 2 * DW;
  localparam int LW  = $clog2(DDW + 2) + 1;

  logic [LW-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          lat_cnt <= '0;
    else if (accept_evt) lat_cnt <= '0;
    else if (busy)       lat_cnt <= lat_cnt + 1'b1;
  end

  p_zero_nowrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> (done && !we_lo && !we_hi && !flag_upd));

  p_zero_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> ($stable({flag_n, flag_z, flag_v}) && $stable(res_lo) && $stable(res_hi)));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && flag_v) |-> (!we_lo && !we_hi && !flag_z));

  p_ovf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && flag_v) |-> ($stable(flag_n) && $stable(res_lo) && $stable(res_hi)));

  p_success_v_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we_lo |-> (flag_upd && !flag_v && done));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == LW'(DDW + 1)));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy);

  p_idle_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind div_unit div_unit_chk #(.DW(DW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept_evt (accept_evt),
  .busy       (busy),
  .done       (done),
  .res_lo     (res_lo),
  .res_hi     (res_hi),
  .we_lo      (we_lo),
  .we_hi      (we_hi),
  .flag_upd   (flag_upd),
  .flag_n     (flag_n),
  .flag_z     (flag_z),
  .flag_v     (flag_v),
  .div_zero   (div_zero)
);

// File: tb/test_div_unit.sv
module test_div_unit;
  localparam int DW  = 32;
  localparam int LAT = 2 * DW + 1;
  localparam int NV  = 18;

  typedef struct packed {
    logic [1:0]  m;
    logic [31:0] hi;
    logic [31:0] lo;
    logic [31:0] dv;
    logic [1:0]  cls;   // 0 success, 1 overflow, 2 divide by zero
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{2'd0, 32'h0,        32'd100,      32'd7,        2'd0},
    '{2'd0, 32'h0,        32'h0000FFFF, 32'd1,        2'd0},
    '{2'd0, 32'h0,        32'h00010000, 32'd1,        2'd1},
    '{2'd0, 32'h0,        32'd5,        32'd10,       2'd0},
    '{2'd0, 32'h0,        32'd1234,     32'd0,        2'd2},
    '{2'd1, 32'h0,        32'hFFFFFF9C, 32'd7,        2'd0},
    '{2'd1, 32'h0,        32'd100,      32'h0000FFF9, 2'd0},
    '{2'd1, 32'h0,        32'hFFFF8000, 32'd1,        2'd0},
    '{2'd1, 32'h0,        32'h00008000, 32'd1,        2'd1},
    '{2'd1, 32'h0,        32'h00008000, 32'h0000FFFF, 2'd0},
    '{2'd1, 32'h0,        32'd7,        32'h00010000, 2'd2},
    '{2'd2, 32'h1,        32'h0,        32'd2,        2'd0},
    '{2'd2, 32'h12345678, 32'h9ABCDEF0, 32'h12345679, 2'd0},
    '{2'd2, 32'h2,        32'h0,        32'd2,        2'd1},
    '{2'd3, 32'hFFFFFFFF, 32'hFFFFFF00, 32'd3,        2'd0},
    '{2'd3, 32'h0,        32'h80000000, 32'hFFFFFFFF, 2'd0},
    '{2'd3, 32'h0,        32'h80000000, 32'd1,        2'd1},
    '{2'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0,        2'd2}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [DW-1:0] src_hi = '0;
  logic [DW-1:0] src_lo = '0;
  logic [DW-1:0] divisor = '0;
  logic          busy, done, we_lo, we_hi, flag_upd;
  logic          flag_n, flag_z, flag_v, flag_c, div_zero;
  logic [DW-1:0] res_lo, res_hi;

  int n_chk  = 0;
  int n_fail = 0;

  // bench-side copy of the architectural state expected at the ports
  logic [31:0] exp_lo = '0;
  logic [31:0] exp_hi = '0;
  logic        exp_n = 1'b0, exp_z = 1'b0, exp_v = 1'b0;

  always #5 clk = ~clk;

  div_unit #(.DW(DW)) i_div_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .src_hi(src_hi), .src_lo(src_lo), .divisor(divisor),
    .busy(busy), .done(done), .res_lo(res_lo), .res_hi(res_hi),
    .we_lo(we_lo), .we_hi(we_hi), .flag_upd(flag_upd),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .div_zero(div_zero)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] m, input logic [31:0] hi, lo, dv,
                       output logic [31:0] r_lo, r_hi, output logic [1:0] cls,
                       output logic n, z);
    logic signed [65:0] num, den, q, r;
    case (m)
      2'd0: begin num = {34'b0, lo};           den = {50'b0, dv[15:0]}; end
      2'd1: begin num = {{34{lo[31]}}, lo};    den = {{50{dv[15]}}, dv[15:0]}; end
      2'd2: begin num = {2'b0, hi, lo};        den = {34'b0, dv}; end
      default: begin num = {{2{hi[31]}}, hi, lo}; den = {{34{dv[31]}}, dv}; end
    endcase
    r_lo = '0; r_hi = '0; n = 1'b0; z = 1'b0;
    if (den == 0) begin
      cls = 2'd2;
    end else begin
      q = num / den;
      r = num % den;
      case (m)
        2'd0: cls = (q > 66'sd65535) ? 2'd1 : 2'd0;
        2'd1: cls = (q > 66'sd32767 || q < -66'sd32768) ? 2'd1 : 2'd0;
        2'd2: cls = (q > 66'sd4294967295) ? 2'd1 : 2'd0;
        default: cls = (q > 66'sd2147483647 || q < -66'sd2147483648) ? 2'd1 : 2'd0;
      endcase
      if (m[1]) begin
        r_lo = q[31:0]; r_hi = r[31:0]; n = q[31]; z = (q[31:0] == 0);
      end else begin
        r_lo = {r[15:0], q[15:0]}; n = q[15]; z = (q[15:0] == 0);
      end
    end
  endtask

  task automatic run_op(input logic [1:0] m, input logic [31:0] hi, lo, dv,
                        input logic [1:0] tbl_cls, input logic poke);
    logic [31:0] m_lo, m_hi;
    logic [1:0]  cls;
    logic        m_n, m_z;
    int          n;
    model(m, hi, lo, dv, m_lo, m_hi, cls, m_n, m_z);
    check("R3 vector class agrees with model", 64'(cls), 64'(tbl_cls));
    @(negedge clk);
    mode = m; src_hi = hi; src_lo = lo; divisor = dv; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      if (poke && n == 5) begin
        start = 1'b1; mode = ~m; src_lo = ~lo; divisor = dv + 32'd3;
      end else if (poke && n == 6) begin
        start = 1'b0;
      end
      if (n == 10) check("R8 busy during run", 64'(busy), 64'd1);
      @(posedge clk); n++;
      @(negedge clk);
    end
    check("R8 latency", 64'(n), 64'(LAT));
    check("R8 busy low at done", 64'(busy), 64'd0);
    if (cls == 2'd0) begin
      exp_lo = m_lo;
      if (m[1]) exp_hi = m_hi;
      exp_n = m_n; exp_z = m_z; exp_v = 1'b0;
    end else if (cls == 2'd1) begin
      exp_z = 1'b0; exp_v = 1'b1;
    end
    case (cls)
      2'd2: begin
        check("R1 div_zero", 64'(div_zero), 64'd1);
        check("R1 no write", 64'({we_lo, we_hi, flag_upd}), 64'd0);
      end
      2'd1: begin
        check("R4 overflow no write", 64'({we_lo, we_hi, div_zero}), 64'd0);
        check("R4 flag_upd", 64'(flag_upd), 64'd1);
      end
      default: begin
        check(m[1] ? "R6 write strobes" : "R2 write strobes",
              64'({we_lo, we_hi}), m[1] ? 64'd3 : 64'd2);
        check("R5 flag_upd", 64'(flag_upd), 64'd1);
      end
    endcase
    check(m[0] ? "R7 res_lo" : (m[1] ? "R6 res_lo" : "R2 res_lo"), 64'(res_lo), 64'(exp_lo));
    check(m[1] ? "R6 res_hi" : "R2 res_hi held", 64'(res_hi), 64'(exp_hi));
    check(cls == 2'd1 ? "R4 flag_n held" : "R5 flag_n", 64'(flag_n), 64'(exp_n));
    check("R5 flag_z", 64'(flag_z), 64'(exp_z));
    check("R4 flag_v", 64'(flag_v), 64'(exp_v));
    check("R5 flag_c", 64'(flag_c), 64'd0);
    @(negedge clk);
    check("R8 done one cycle", 64'(done), 64'd0);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset busy/done", 64'({busy, done}), 64'd0);
    check("R2 reset results", {res_hi, res_lo}, 64'd0);
    check("R5 reset flags", 64'({flag_n, flag_z, flag_v, flag_c, we_lo, we_hi, div_zero}), 64'd0);

    for (int i = 0; i < NV; i++)
      run_op(VT[i].m, VT[i].hi, VT[i].lo, VT[i].dv, VT[i].cls, 1'b0);

    // R9: second start mid-run is dropped
    run_op(2'd0, 32'h0, 32'd1000, 32'd9, 2'd0, 1'b1);
    // R4: overflow right after a negative success keeps N and results
    run_op(2'd3, 32'hFFFFFFFF, 32'hFFFFFFF6, 32'd4, 2'd0, 1'b0);
    run_op(2'd2, 32'hFFFFFFFF, 32'h0, 32'd1, 2'd1, 1'b0);
    // R1: zero divisor after an overflow leaves V set
    run_op(2'd0, 32'h0, 32'd77, 32'hFFFF0000, 2'd2, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule